// File: doc/BRIEF.md
# Bit-Packing Elastic Word Buffer

This block sits between a serial data-recovery stage and a parallel consumer. Recovered bits arrive one at a time with a qualifying strobe on the sampling-side clock. The block gathers them into words of 5 bits by default, or 8 bits by parameter, and stores each finished word in a 16-entry circular store. An independent parallel-side clock, running at the word rate, takes the words out.

The store lets the two clocks drift in phase against each other. It also absorbs the odd bit that the recovery logic adds or drops. After reset the reader holds off until half the entries are occupied. The buffer therefore begins centred and can take the largest offset in either direction.

When the writer finds the store full, the incoming word is discarded and a sticky overrun flag is raised. When the running reader finds the store empty, the last word is presented again and a sticky underrun flag is raised. Pointers cross between the clock domains in Gray code.

Top module: `bitpack_elastic_buf`

## Requirements
- R1: Bits are packed least significant first. The first bit accepted after a word boundary lands in bit 0 of the word, and the last one lands in bit WORD_W-1.
- R2: The parameter WORD_W selects the word width. A width of 8 packs and delivers 8-bit words with the same ordering as the default width of 5.
- R3: Words leave the buffer in the order they were packed. The store holds up to 16 words without loss.
- R4: After reset, par_valid stays low and no word is read while fewer than 8 words are held. Reading starts once 8 or more words are held, and par_valid rises together with the first word delivered.
- R5: A word completed while 16 words are held is discarded, and the write pointer does not move. overrun rises and stays high until reset.
- R6: When reading has started and the store is empty, par_word keeps its previous value. underrun rises and stays high until reset.
- R7: Reset clears par_valid, overrun and underrun, and empties both pointers so that the half-fill wait applies again.
- R8: Once par_valid has risen, it stays high until the next reset.
- R9: Each pointer crossing a clock domain is Gray coded. Between consecutive clock edges of its own domain it changes in at most one bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Sampling-side clock for bit intake, packing and writes |
| rd_clk | input | 1 | Parallel-side clock for reads |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| ser_bit | input | 1 | Recovered data bit |
| ser_vld | input | 1 | Qualifies ser_bit on the current wr_clk edge |
| par_word | output | WORD_W | Word delivered on the parallel side |
| par_valid | output | 1 | High once the first real word has been delivered |
| overrun | output | 1 | Sticky flag in the wr_clk domain: a word was dropped because the store was full |
| underrun | output | 1 | Sticky flag in the rd_clk domain: a word was repeated because the store was empty |

## Verification
A packed word is written on the wr_clk edge after its last bit. The reader sees the new write pointer two rd_clk edges later and presents the word on the next rd_clk edge. A flag follows one edge after the condition in its own domain. The bench therefore never predicts a cycle position across the clock crossing. It records the sequence of words delivered while par_valid is high and compares it with the arithmetic sequence it sent. It checks flags and par_valid only after idle windows of many cycles in both domains, so every pending crossing has settled. The assertions check the single-domain timing edge by edge, for example that a dropped word leaves the write pointer unchanged on the next wr_clk.

// File: rtl/ebuf_pkg.sv
package ebuf_pkg;
  localparam int unsigned AW    = 4;
  localparam int unsigned DEPTH = 1 << AW;
  localparam int unsigned PW    = AW + 1;
  localparam int unsigned HALF  = DEPTH / 2;

  typedef logic [PW-1:0] ptr_t;

  function automatic ptr_t bin2gray(input ptr_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic ptr_t gray2bin(input ptr_t g);
    ptr_t b;
    b[PW-1] = g[PW-1];
    for (int i = int'(PW) - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // words held between a head (write) and tail (read) pointer
  function automatic ptr_t fill_level(input ptr_t head, input ptr_t tail);
    return head - tail;
  endfunction
endpackage

// File: rtl/ebuf_sync.sv
module ebuf_sync #(
  parameter int unsigned W      = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(STAGES); i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < int'(STAGES); i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/ebuf_packer.sv
module ebuf_packer #(
  parameter int unsigned WORD_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_in,
  input  logic              bit_vld,
  output logic [WORD_W-1:0] word,
  output logic              word_stb
);
  localparam int unsigned CW = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

  logic [CW-1:0]     cnt;
  logic [WORD_W-1:0] acc;

  function automatic logic [WORD_W-1:0] place_bit(input logic [WORD_W-1:0] w,
                                                  input logic [CW-1:0] pos,
                                                  input logic b);
    logic [WORD_W-1:0] r;
    r = w;
    r[pos] = b;
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      acc      <= '0;
      word     <= '0;
      word_stb <= 1'b0;
    end else begin
      word_stb <= 1'b0;
      if (bit_vld) begin
        acc <= place_bit(acc, cnt, bit_in);
        if (cnt == LAST) begin
          word     <= place_bit(acc, cnt, bit_in);
          word_stb <= 1'b1;
          cnt      <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ebuf_wr_ctrl.sv
module ebuf_wr_ctrl
  import ebuf_pkg::*;
(
  input  logic          wr_clk,
  input  logic          rst_n,
  input  logic          word_stb,
  input  ptr_t          rd_gray_s,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output ptr_t          wr_gray,
  output logic          full,
  output logic          overrun
);
  ptr_t wbin, occ;

  assign occ     = fill_level(wbin, gray2bin(rd_gray_s));
  assign full    = occ[PW-1];
  assign wr_en   = word_stb & ~full;
  assign wr_addr = wbin[AW-1:0];

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin    <= '0;
      wr_gray <= '0;
      overrun <= 1'b0;
    end else begin
      if (wr_en) begin
        wbin    <= wbin + ptr_t'(1);
        wr_gray <= bin2gray(wbin + ptr_t'(1));
      end
      if (word_stb && full) overrun <= 1'b1;
    end
  end
endmodule

// File: rtl/ebuf_rd_ctrl.sv
module ebuf_rd_ctrl
  import ebuf_pkg::*;
(
  input  logic          rd_clk,
  input  logic          rst_n,
  input  ptr_t          wr_gray_s,
  output logic          rd_fire,
  output logic [AW-1:0] rd_addr,
  output ptr_t          rd_gray,
  output logic          started,
  output logic          empty,
  output logic          underrun
);
  ptr_t rbin, occ;

  assign occ     = fill_level(gray2bin(wr_gray_s), rbin);
  assign empty   = (occ == '0);
  assign rd_fire = started & ~empty;
  assign rd_addr = rbin[AW-1:0];

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin     <= '0;
      rd_gray  <= '0;
      started  <= 1'b0;
      underrun <= 1'b0;
    end else begin
      if (!started) begin
        if (occ >= ptr_t'(HALF)) started <= 1'b1;
      end else if (empty) begin
        underrun <= 1'b1;
      end
      if (rd_fire) begin
        rbin    <= rbin + ptr_t'(1);
        rd_gray <= bin2gray(rbin + ptr_t'(1));
      end
    end
  end
endmodule

// File: rtl/bitpack_elastic_buf.sv
module bitpack_elastic_buf
  import ebuf_pkg::*;
#(
  parameter int unsigned WORD_W = 5
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              ser_bit,
  input  logic              ser_vld,
  output logic [WORD_W-1:0] par_word,
  output logic              par_valid,
  output logic              overrun,
  output logic              underrun
);
  logic [WORD_W-1:0] pk_word;
  logic              pk_stb;
  logic              wr_en, wr_full;
  logic [AW-1:0]     wr_addr, rd_addr;
  ptr_t              wr_gray, wr_gray_s, rd_gray, rd_gray_s;
  logic              rd_fire, rd_started, rd_empty;
  logic [WORD_W-1:0] mem [DEPTH];

  ebuf_packer #(.WORD_W(WORD_W)) u_pack (
    .clk(wr_clk), .rst_n(rst_n), .bit_in(ser_bit), .bit_vld(ser_vld),
    .word(pk_word), .word_stb(pk_stb)
  );

  ebuf_wr_ctrl u_wr (
    .wr_clk(wr_clk), .rst_n(rst_n), .word_stb(pk_stb), .rd_gray_s(rd_gray_s),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_gray(wr_gray), .full(wr_full),
    .overrun(overrun)
  );

  ebuf_rd_ctrl u_rd (
    .rd_clk(rd_clk), .rst_n(rst_n), .wr_gray_s(wr_gray_s), .rd_fire(rd_fire),
    .rd_addr(rd_addr), .rd_gray(rd_gray), .started(rd_started),
    .empty(rd_empty), .underrun(underrun)
  );

  ebuf_sync #(.W(PW), .STAGES(2)) u_w2r (
    .clk(rd_clk), .rst_n(rst_n), .d(wr_gray), .q(wr_gray_s)
  );

  ebuf_sync #(.W(PW), .STAGES(2)) u_r2w (
    .clk(wr_clk), .rst_n(rst_n), .d(rd_gray), .q(rd_gray_s)
  );

  always_ff @(posedge wr_clk) begin
    if (wr_en) mem[wr_addr] <= pk_word;
  end

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      par_word  <= '0;
      par_valid <= 1'b0;
    end else if (rd_fire) begin
      par_word  <= mem[rd_addr];
      par_valid <= 1'b1;
    end
  end
endmodule

// File: rtl/ebuf_checker.sv
module ebuf_checker
  import ebuf_pkg::*;
#(
  parameter int unsigned WORD_W = 5
) (
  input logic              wr_clk,
  input logic              rd_clk,
  input logic              rst_n,
  input logic              pk_stb,
  input logic              wr_full,
  input ptr_t              wr_gray,
  input ptr_t              rd_gray,
  input logic              rd_started,
  input logic              rd_empty,
  input logic [WORD_W-1:0] par_word,
  input logic              par_valid,
  input logic              overrun,
  input logic              underrun
);
  AST_OVR_STICKY: assert property (@(posedge wr_clk) disable iff (!rst_n)
    overrun |=> overrun); // R5
  AST_OVR_DROP: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (pk_stb && wr_full) |=> $stable(wr_gray)); // R5
  AST_WR_GRAY_STEP: assert property (@(posedge wr_clk) disable iff (!rst_n)
    $countones(wr_gray ^ $past(wr_gray)) <= 1); // R9
  AST_RD_GRAY_STEP: assert property (@(posedge rd_clk) disable iff (!rst_n)
    $countones(rd_gray ^ $past(rd_gray)) <= 1); // R9
  AST_UND_STICKY: assert property (@(posedge rd_clk) disable iff (!rst_n)
    underrun |=> underrun); // R6
  AST_UND_HOLD: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (rd_started && rd_empty) |=> $stable(par_word)); // R6
  AST_VALID_KEEP: assert property (@(posedge rd_clk) disable iff (!rst_n)
    par_valid |=> par_valid); // R8
  AST_VALID_NEEDS_START: assert property (@(posedge rd_clk) disable iff (!rst_n)
    par_valid |-> rd_started); // R4
endmodule

bind bitpack_elastic_buf ebuf_checker #(.WORD_W(WORD_W)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .pk_stb(pk_stb),
  .wr_full(wr_full), .wr_gray(wr_gray), .rd_gray(rd_gray),
  .rd_started(rd_started), .rd_empty(rd_empty), .par_word(par_word),
  .par_valid(par_valid), .overrun(overrun), .underrun(underrun)
);

// File: tb/tb_bitpack_elastic_buf.sv
`timescale 1ns/1ps
module tb_bitpack_elastic_buf;
  logic clk = 1'b0, rd_clk = 1'b0, rd_clk8 = 1'b0, rst_n = 1'b0, rd_run = 1'b1;
  logic b5 = 1'b0, v5 = 1'b0, b8 = 1'b0, v8 = 1'b0;
  logic [4:0] w5;
  logic [7:0] w8;
  logic pv5, ov5, un5, pv8, ov8, un8;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0, cap5 = 1'b0, cap8 = 1'b0;
  logic [4:0] got5 [64];
  logic [7:0] got8 [64];
  int n5 = 0, n8 = 0;

  always #2.5 clk = ~clk;
  initial forever begin #12.5; if (rd_run) rd_clk = ~rd_clk; end
  always #20 rd_clk8 = ~rd_clk8;

  bitpack_elastic_buf #(.WORD_W(5)) dut (
    .wr_clk(clk), .rd_clk(rd_clk), .rst_n(rst_n), .ser_bit(b5), .ser_vld(v5),
    .par_word(w5), .par_valid(pv5), .overrun(ov5), .underrun(un5));

  bitpack_elastic_buf #(.WORD_W(8)) dut_w8 (
    .wr_clk(clk), .rd_clk(rd_clk8), .rst_n(rst_n), .ser_bit(b8), .ser_vld(v8),
    .par_word(w8), .par_valid(pv8), .overrun(ov8), .underrun(un8));

  always @(negedge rd_clk)
    if (!cap5) n5 <= 0;
    else if (pv5 && n5 < 64) begin got5[n5] <= w5; n5 <= n5 + 1; end

  always @(negedge rd_clk8)
    if (!cap8) n8 <= 0;
    else if (pv8 && n8 < 64) begin got8[n8] <= w8; n8 <= n8 + 1; end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (20) @(negedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send5(input int v);
    for (int b = 0; b < 5; b++) begin
      @(negedge clk); b5 = v[b]; v5 = 1'b1;
    end
  endtask

  task automatic send8(input int v);
    for (int b = 0; b < 8; b++) begin
      @(negedge clk); b8 = v[b]; v8 = 1'b1;
    end
  endtask

  task automatic idle();
    @(negedge clk); v5 = 1'b0; v8 = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog all requirements actual=0 expected=1");
      summary();
      $finish;
    end
  end

  initial begin
    do_reset();
    // R7: state after reset
    check(pv5 == 1'b0, "R7 par_valid after reset", int'(pv5), 0);
    check(ov5 == 1'b0, "R7 overrun after reset", int'(ov5), 0);
    check(un5 == 1'b0, "R7 underrun after reset", int'(un5), 0);
    check(pv8 == 1'b0, "R7 par_valid w8 after reset", int'(pv8), 0);

    // Phase 1: every 5-bit value once, with a pause below half fill
    cap5 = 1'b1;
    for (int i = 0; i < 7; i++) send5(i);
    idle();
    repeat (40) @(negedge clk);
    check(pv5 == 1'b0, "R4 no output with 7 words held", int'(pv5), 0);
    check(n5 == 0, "R4 no word read below half fill", n5, 0);
    for (int i = 7; i < 32; i++) send5(i);
    idle();
    repeat (200) @(negedge clk);
    check(n5 > 32, "R6 repeats after drain", n5, 33);
    check(got5[1] == 5'd1, "R1 first bit lands in bit 0", int'(got5[1]), 1);
    for (int i = 0; i < 32; i++)
      check(got5[i] == 5'(i), "R1 R3 R9 word order", int'(got5[i]), i);
    for (int i = 32; i < n5; i++)
      check(got5[i] == 5'd31, "R6 last word repeated", int'(got5[i]), 31);
    check(un5 == 1'b1, "R6 underrun after drain", int'(un5), 1);
    check(ov5 == 1'b0, "R5 no overrun at matched rate", int'(ov5), 0);
    check(pv5 == 1'b1, "R8 par_valid held through underrun", int'(pv5), 1);

    // Phase 2: fill with reader stopped, then overflow by one
    cap5 = 1'b0;
    do_reset();
    check(un5 == 1'b0, "R7 underrun cleared by reset", int'(un5), 0);
    check(pv5 == 1'b0, "R7 par_valid cleared by reset", int'(pv5), 0);
    @(negedge rd_clk);
    rd_run = 1'b0;
    for (int i = 0; i < 16; i++) send5(10 + i);
    idle();
    repeat (10) @(negedge clk);
    check(ov5 == 1'b0, "R3 sixteen words accepted", int'(ov5), 0);
    send5(26);
    idle();
    repeat (5) @(negedge clk);
    check(ov5 == 1'b1, "R5 overrun on seventeenth word", int'(ov5), 1);
    cap5 = 1'b1;
    rd_run = 1'b1;
    repeat (300) @(negedge clk);
    check(n5 > 16, "R6 repeats after full drain", n5, 17);
    for (int i = 0; i < 16; i++)
      check(got5[i] == 5'(10 + i), "R3 R5 stored words intact", int'(got5[i]), 10 + i);
    for (int i = 16; i < n5; i++)
      check(got5[i] == 5'd25, "R5 dropped word absent", int'(got5[i]), 25);
    check(ov5 == 1'b1, "R5 overrun sticky", int'(ov5), 1);
    check(un5 == 1'b1, "R6 underrun after drain", int'(un5), 1);

    // Phase 3: 8-bit width
    do_reset();
    cap8 = 1'b1;
    for (int i = 0; i < 40; i++) send8((i * 37 + 11) & 255);
    idle();
    repeat (400) @(negedge clk);
    check(n8 >= 40, "R2 byte count", n8, 40);
    for (int i = 0; i < 40; i++)
      check(got8[i] == 8'((i * 37 + 11) & 255), "R2 R1 byte order", int'(got8[i]),
            (i * 37 + 11) & 255);
    check(ov8 == 1'b0, "R2 no overrun w8", int'(ov8), 0);
    check(un8 == 1'b1, "R6 underrun w8 after drain", int'(un8), 1);
    check(pv8 == 1'b1, "R8 par_valid w8 held", int'(pv8), 1);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule